// File: doc/BRIEF.md
# Parallel Display Bus Controller

This block is the host side of an 8-bit parallel display bus. It turns single-byte write and read requests into bus accesses. Each access drives an active-low chip select, a command/data select line, an active-low write strobe or an active-low read strobe, and the data lines. The host places a byte and its select-line value in a one-byte write buffer. It can also queue one read request. Completed reads land in a one-byte read buffer that the host pops. Two level interrupts flag the buffer states: write buffer empty and read buffer holding data. Two one-cycle DMA request pulses mark the same events, so a DMA engine can refill or drain the buffers.

An access runs through four named states. `PH_IDLE` has chip select released. On leaving it, the sequencer picks up work: a buffered write is taken first, otherwise a pending read. `PH_SETUP` has chip select and the select line active and lasts the programmed setup count. `PH_STROBE` holds the write or read strobe low for the programmed wait count plus one. `PH_HOLD` keeps chip select low for the programmed hold count after the strobe releases. The transitions are IDLE→SETUP when work is taken and setup is non-zero, and IDLE→STROBE when setup is zero. SETUP→STROBE happens when the setup count expires. STROBE→HOLD happens when the strobe count expires and hold is non-zero, and STROBE→IDLE happens when hold is zero. HOLD→IDLE happens when the hold count expires. Every access returns to `PH_IDLE` for at least one cycle. With a zero setup count, chip select and the strobe fall in the same cycle.

The data lines are split into an output, an output enable and an input. An external pad ring combines them into a tri-state bus.

Top module: `pdb_ctrl`

## Requirements
- R1: After reset, disp_cs_n, disp_wr_n and disp_rd_n are high, disp_oe is low, irq_wempty is high, irq_rfull is low and no DMA pulse is present.
- R2: In each access, disp_cs_n falls with disp_a0 valid. The strobe then stays high for exactly cfg_setup cycles (0 to 15) before it falls.
- R3: In each access exactly one strobe (disp_wr_n for a write, disp_rd_n for a read) is low, for exactly cfg_wait+1 consecutive cycles, and the other strobe stays high.
- R4: After the strobe releases, disp_cs_n stays low for exactly cfg_hold cycles, then goes high for at least one cycle before the next access.
- R5: disp_a0 is constant through an access and equals the select value of the request. disp_oe is high for the whole of a write access and low otherwise. disp_dout equals the written byte while disp_wr_n is low.
- R6: A read captures disp_din at the clock edge where disp_rd_n rises. It then sets irq_rfull and presents the byte on rdata. A one-cycle host_pop clears irq_rfull.
- R7: A write request is accepted when the write buffer is empty or is being handed to the bus in the same cycle. A request that finds the buffer full is ignored and produces no access. A byte written during an access waits in the buffer and starts once the bus is back in PH_IDLE.
- R8: One read request is held pending. A further read request while one is pending is ignored. When a write and a read are both waiting in PH_IDLE, the write goes first.
- R9: irq_wempty is high exactly when the write buffer holds no byte. It goes low in the cycle after an accepted write request when the bus is idle.
- R10: dma_wr pulses for one cycle each time a buffered byte is handed to the bus. dma_rd pulses for one cycle each time read data arrives in the read buffer, in the cycle where disp_rd_n has just risen.
- R11: cfg_wait and cfg_hold are sampled when an access starts. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write request, one cycle |
| host_wr_a0 | input | 1 | Select-line value for the write (0 command, 1 data) |
| host_wr_data | input | 8 | Byte to write |
| host_rd | input | 1 | Read request, one cycle |
| host_rd_a0 | input | 1 | Select-line value for the read |
| host_pop | input | 1 | Host has taken the read buffer byte |
| cfg_setup | input | 4 | Setup cycles before the strobe |
| cfg_wait | input | 4 | Strobe low time minus one |
| cfg_hold | input | 4 | Hold cycles after the strobe |
| rdata | output | 8 | Read buffer contents |
| irq_wempty | output | 1 | Write buffer empty interrupt (level) |
| irq_rfull | output | 1 | Read buffer full interrupt (level) |
| dma_wr | output | 1 | DMA request: write buffer emptied (pulse) |
| dma_rd | output | 1 | DMA request: read buffer filled (pulse) |
| disp_cs_n | output | 1 | Chip select, active low |
| disp_a0 | output | 1 | Command/data select |
| disp_wr_n | output | 1 | Write strobe, active low |
| disp_rd_n | output | 1 | Read strobe, active low |
| disp_dout | output | 8 | Data lines, outgoing value |
| disp_oe | output | 1 | Data line output enable |
| disp_din | input | 8 | Data lines, incoming value |

## Verification
The assertions check the following on every cycle:
- the two strobes are never low together;
- a strobe only appears inside chip select;
- the output enable never overlaps a read strobe;
- the select line stays steady while chip select is held;
- each DMA pulse is a single cycle tied to its bus event;
- read data arrives exactly as the read strobe rises.

Only the bench scenarios can show the following:
- the exact setup, strobe and hold lengths against the programmed counts;
- sampling of the timing fields at access start;
- buffer acceptance and dropping;
- write-before-read ordering;
- the captured read byte.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    // Bus sequencer states, in the order an access walks through them
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } pdb_phase_e;

    // Kind of the access currently owning the bus
    typedef struct packed {
        logic is_wr;
        logic a0;
    } pdb_kind_t;

endpackage

// File: rtl/pdb_hostbuf.sv
module pdb_hostbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          wr_a0,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic          rd_a0,
    input  logic          rd_pop,
    input  logic          take_wr,
    input  logic          take_rd,
    input  logic          rd_done,
    input  logic [DW-1:0] bus_din,
    output logic          wb_valid,
    output logic          wb_a0,
    output logic [DW-1:0] wb_data,
    output logic          rp_valid,
    output logic          rp_a0,
    output logic [DW-1:0] rb_data,
    output logic          rb_valid,
    output logic          dma_wr,
    output logic          dma_rd
);

    // Write buffer: a slot frees in the same cycle it is handed to the bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_a0    <= 1'b0;
            wb_data  <= '0;
        end else if (wr_req && (!wb_valid || take_wr)) begin
            wb_valid <= 1'b1;
            wb_a0    <= wr_a0;
            wb_data  <= wr_data;
        end else if (take_wr) begin
            wb_valid <= 1'b0;
        end
    end

    // Pending read request, one deep
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_valid <= 1'b0;
            rp_a0    <= 1'b0;
        end else if (rd_req && (!rp_valid || take_rd)) begin
            rp_valid <= 1'b1;
            rp_a0    <= rd_a0;
        end else if (take_rd) begin
            rp_valid <= 1'b0;
        end
    end

    // Read buffer: new data wins over a simultaneous pop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_valid <= 1'b0;
            rb_data  <= '0;
        end else if (rd_done) begin
            rb_valid <= 1'b1;
            rb_data  <= bus_din;
        end else if (rd_pop) begin
            rb_valid <= 1'b0;
        end
    end

    // DMA request pulses, registered so they line up with the bus event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_wr <= 1'b0;
            dma_rd <= 1'b0;
        end else begin
            dma_wr <= take_wr;
            dma_rd <= rd_done;
        end
    end

endmodule

// File: rtl/pdb_seq.sv
module pdb_seq
    import pdb_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_valid,
    input  logic          wb_a0,
    input  logic [DW-1:0] wb_data,
    input  logic          rp_valid,
    input  logic          rp_a0,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_wait,
    input  logic [TW-1:0] cfg_hold,
    output logic          take_wr,
    output logic          take_rd,
    output logic          rd_done,
    output logic          cs_n,
    output logic          a0,
    output logic          wr_n,
    output logic          rd_n,
    output logic [DW-1:0] dout,
    output logic          oe
);

    localparam logic [TW-1:0] ONE = TW'(1);

    pdb_phase_e    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    pdb_kind_t     kind_q;
    logic [DW-1:0] data_q;
    logic [TW-1:0] wait_q, hold_q;

    // Next-state and phase counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        take_wr = 1'b0;
        take_rd = 1'b0;
        rd_done = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (wb_valid) begin
                    take_wr = 1'b1;
                end else if (rp_valid) begin
                    take_rd = 1'b1;
                end
                if (wb_valid || rp_valid) begin
                    if (cfg_setup != '0) begin
                        state_d = PH_SETUP;
                        cnt_d   = cfg_setup - ONE;
                    end else begin
                        state_d = PH_STROBE;
                        cnt_d   = cfg_wait;
                    end
                end
            end
            PH_SETUP: begin
                if (cnt_q == '0) begin
                    state_d = PH_STROBE;
                    cnt_d   = wait_q;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            PH_STROBE: begin
                if (cnt_q == '0) begin
                    rd_done = !kind_q.is_wr;
                    if (hold_q != '0) begin
                        state_d = PH_HOLD;
                        cnt_d   = hold_q - ONE;
                    end else begin
                        state_d = PH_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            PH_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = PH_IDLE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        endcase
    end

    // State register and per-access latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            kind_q  <= '0;
            data_q  <= '0;
            wait_q  <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (take_wr || take_rd) begin
                kind_q.is_wr <= take_wr;
                kind_q.a0    <= take_wr ? wb_a0 : rp_a0;
                wait_q       <= cfg_wait;
                hold_q       <= cfg_hold;
            end
            if (take_wr) begin
                data_q <= wb_data;
            end
        end
    end

    // Bus outputs decoded from the state register
    always_comb begin
        cs_n = (state_q == PH_IDLE);
        wr_n = !((state_q == PH_STROBE) && kind_q.is_wr);
        rd_n = !((state_q == PH_STROBE) && !kind_q.is_wr);
        oe   = (state_q != PH_IDLE) && kind_q.is_wr;
        a0   = kind_q.a0;
        dout = data_q;
    end

endmodule

// File: rtl/pdb_ctrl.sv
module pdb_ctrl #(
    parameter int DW = 8,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_wr_a0,
    input  logic [DW-1:0] host_wr_data,
    input  logic          host_rd,
    input  logic          host_rd_a0,
    input  logic          host_pop,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_wait,
    input  logic [TW-1:0] cfg_hold,
    output logic [DW-1:0] rdata,
    output logic          irq_wempty,
    output logic          irq_rfull,
    output logic          dma_wr,
    output logic          dma_rd,
    output logic          disp_cs_n,
    output logic          disp_a0,
    output logic          disp_wr_n,
    output logic          disp_rd_n,
    output logic [DW-1:0] disp_dout,
    output logic          disp_oe,
    input  logic [DW-1:0] disp_din
);

    logic          wb_valid, wb_a0, rp_valid, rp_a0, rb_valid;
    logic [DW-1:0] wb_data;
    logic          take_wr, take_rd, rd_done;

    pdb_hostbuf #(.DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (host_wr),
        .wr_a0    (host_wr_a0),
        .wr_data  (host_wr_data),
        .rd_req   (host_rd),
        .rd_a0    (host_rd_a0),
        .rd_pop   (host_pop),
        .take_wr  (take_wr),
        .take_rd  (take_rd),
        .rd_done  (rd_done),
        .bus_din  (disp_din),
        .wb_valid (wb_valid),
        .wb_a0    (wb_a0),
        .wb_data  (wb_data),
        .rp_valid (rp_valid),
        .rp_a0    (rp_a0),
        .rb_data  (rdata),
        .rb_valid (rb_valid),
        .dma_wr   (dma_wr),
        .dma_rd   (dma_rd)
    );

    pdb_seq #(.DW(DW), .TW(TW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_valid  (wb_valid),
        .wb_a0     (wb_a0),
        .wb_data   (wb_data),
        .rp_valid  (rp_valid),
        .rp_a0     (rp_a0),
        .cfg_setup (cfg_setup),
        .cfg_wait  (cfg_wait),
        .cfg_hold  (cfg_hold),
        .take_wr   (take_wr),
        .take_rd   (take_rd),
        .rd_done   (rd_done),
        .cs_n      (disp_cs_n),
        .a0        (disp_a0),
        .wr_n      (disp_wr_n),
        .rd_n      (disp_rd_n),
        .dout      (disp_dout),
        .oe        (disp_oe)
    );

    assign irq_wempty = !wb_valid;
    assign irq_rfull  = rb_valid;

endmodule

// File: rtl/pdb_ctrl_chk.sv
module pdb_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic disp_cs_n,
    input logic disp_a0,
    input logic disp_wr_n,
    input logic disp_rd_n,
    input logic disp_oe,
    input logic dma_wr,
    input logic dma_rd,
    input logic irq_rfull
);

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!disp_wr_n && !disp_rd_n));

    p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_wr_n || !disp_rd_n) |-> !disp_cs_n);

    p_oe_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_oe |-> (!disp_cs_n && disp_rd_n));

    p_a0_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_cs_n && !$past(disp_cs_n)) |-> $stable(disp_a0));

    p_dma_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr |-> (!disp_cs_n && disp_oe) ##1 !dma_wr);

    p_read_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_rd_n) |-> (dma_rd && irq_rfull));

    p_dma_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd |=> !dma_rd);

endmodule

bind pdb_ctrl pdb_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .disp_cs_n (disp_cs_n),
    .disp_a0   (disp_a0),
    .disp_wr_n (disp_wr_n),
    .disp_rd_n (disp_rd_n),
    .disp_oe   (disp_oe),
    .dma_wr    (dma_wr),
    .dma_rd    (dma_rd),
    .irq_rfull (irq_rfull)
);

// File: tb/pdb_ctrl_bench.sv
module pdb_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 0, host_wr_a0 = 0, host_rd = 0, host_rd_a0 = 0, host_pop = 0;
    logic [7:0] host_wr_data = '0, disp_din = '0;
    logic [3:0] cfg_setup = '0, cfg_wait = '0, cfg_hold = '0;
    logic [7:0] rdata, disp_dout;
    logic       irq_wempty, irq_rfull, dma_wr, dma_rd;
    logic       disp_cs_n, disp_a0, disp_wr_n, disp_rd_n, disp_oe;

    int errors = 0, checks = 0;
    int n_dma_wr = 0, n_dma_rd = 0, exp_wr = 0, exp_rd = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pdb_ctrl u_pdb_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wr_a0(host_wr_a0), .host_wr_data(host_wr_data),
        .host_rd(host_rd), .host_rd_a0(host_rd_a0), .host_pop(host_pop),
        .cfg_setup(cfg_setup), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
        .rdata(rdata), .irq_wempty(irq_wempty), .irq_rfull(irq_rfull),
        .dma_wr(dma_wr), .dma_rd(dma_rd),
        .disp_cs_n(disp_cs_n), .disp_a0(disp_a0), .disp_wr_n(disp_wr_n),
        .disp_rd_n(disp_rd_n), .disp_dout(disp_dout), .disp_oe(disp_oe),
        .disp_din(disp_din)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench functions giving the expected phase lengths
    function automatic int exp_strobe(logic [3:0] w);
        return int'(w) + 1;
    endfunction

    always @(negedge clk) if (rst_n) begin
        if (dma_wr) n_dma_wr++;
        if (dma_rd) n_dma_rd++;
    end

    task automatic do_write(logic a0, logic [7:0] d);
        host_wr = 1; host_wr_a0 = a0; host_wr_data = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic do_read(logic a0);
        host_rd = 1; host_rd_a0 = a0;
        @(negedge clk);
        host_rd = 0;
    endtask

    // Watches one access from chip select fall to release
    task automatic observe(bit is_wr, bit ea0, logic [7:0] ed, int es, int ew, int eh);
        int s = 0, w = 0, h = 0, guard = 0;
        bit seen = 0, bad_a0 = 0, bad_oe = 0, bad_d = 0, bad_other = 0;
        bit stb, oth;
        @(negedge clk);
        while (disp_cs_n && guard < 400) begin
            guard++;
            @(negedge clk);
        end
        check("R2 access started", int'(!disp_cs_n), 1);
        while (!disp_cs_n) begin
            stb = is_wr ? !disp_wr_n : !disp_rd_n;
            oth = is_wr ? !disp_rd_n : !disp_wr_n;
            if (oth) bad_other = 1;
            if (disp_a0 !== ea0) bad_a0 = 1;
            if (disp_oe !== is_wr) bad_oe = 1;
            if (stb) begin
                seen = 1; w++;
                if (is_wr && disp_dout !== ed) bad_d = 1;
                if (!is_wr) disp_din = ed;
            end else if (!seen) s++;
            else h++;
            @(negedge clk);
        end
        check("R2 setup cycles", s, es);
        check("R3 strobe cycles", w, exp_strobe(4'(ew)));
        check("R3 other strobe idle", int'(bad_other), 0);
        check("R4 hold cycles", h, eh);
        check("R5 a0 value", int'(bad_a0), 0);
        check("R5 output enable", int'(bad_oe), 0);
        check("R5 write data", int'(bad_d), 0);
        if (is_wr) exp_wr++; else exp_rd++;
    endtask

    task automatic pop_check(logic [7:0] ed);
        check("R6 rfull set", int'(irq_rfull), 1);
        check("R6 read byte", int'(rdata), int'(ed));
        host_pop = 1;
        @(negedge clk);
        host_pop = 0;
        check("R6 pop clears", int'(irq_rfull), 0);
    endtask

    task automatic quiet(int n, string req);
        bit act = 0;
        repeat (n) begin
            @(negedge clk);
            if (!disp_cs_n) act = 1;
        end
        check(req, int'(act), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cs_n", int'(disp_cs_n), 1);
        check("R1 wr_n", int'(disp_wr_n), 1);
        check("R1 rd_n", int'(disp_rd_n), 1);
        check("R1 oe", int'(disp_oe), 0);
        check("R1 wempty", int'(irq_wempty), 1);
        check("R1 rfull", int'(irq_rfull), 0);
        check("R1 dma", int'(dma_wr | dma_rd), 0);
        rst_n = 1;
        @(negedge clk);

        // Directed: widest timing, write then read (R2 R3 R4 R9)
        cfg_setup = 4'd15; cfg_wait = 4'd15; cfg_hold = 4'd15;
        do_write(1'b1, 8'hA5);
        check("R9 wempty low after accept", int'(irq_wempty), 0);
        observe(1, 1, 8'hA5, 15, 15, 15);
        check("R9 wempty back high", int'(irq_wempty), 1);
        cfg_setup = 4'd0; cfg_wait = 4'd0; cfg_hold = 4'd0;
        do_read(1'b0);
        observe(0, 0, 8'h3C, 0, 0, 0);
        pop_check(8'h3C);

        // R7: three back-to-back writes, third dropped
        cfg_setup = 4'd1; cfg_wait = 4'd1; cfg_hold = 4'd1;
        fork
            begin
                do_write(1'b0, 8'h11);
                do_write(1'b1, 8'h22);
                do_write(1'b0, 8'h33);
            end
            begin
                observe(1, 0, 8'h11, 1, 1, 1);
                observe(1, 1, 8'h22, 1, 1, 1);
            end
        join
        quiet(40, "R7 full-buffer write ignored");

        // R8: extra read while pending is ignored; R11 timing sampled at start
        cfg_setup = 4'd3; cfg_wait = 4'd3; cfg_hold = 4'd3;
        fork
            do_write(1'b1, 8'h5A);
            begin
                observe(1, 1, 8'h5A, 3, 3, 3);
            end
            begin
                repeat (3) @(negedge clk);
                cfg_wait = 4'd0; cfg_hold = 4'd2;
                host_rd = 1; host_rd_a0 = 1;
                @(negedge clk);
                host_rd_a0 = 0;
                @(negedge clk);
                host_rd = 0;
            end
        join
        observe(0, 1, 8'hC3, 3, 0, 2);
        pop_check(8'hC3);
        quiet(40, "R8 second read ignored");

        // R8: write and read together, write wins
        cfg_setup = 4'd2; cfg_wait = 4'd1; cfg_hold = 4'd0;
        host_wr = 1; host_wr_a0 = 0; host_wr_data = 8'h77;
        host_rd = 1; host_rd_a0 = 1;
        @(negedge clk);
        host_wr = 0; host_rd = 0;
        observe(1, 0, 8'h77, 2, 1, 0);
        observe(0, 1, 8'h99, 2, 1, 0);
        pop_check(8'h99);

        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [7:0] d;
            logic a;
            logic [3:0] s, w, h;
            d = 8'($urandom); a = 1'($urandom);
            s = 4'($urandom_range(0, 4)); w = 4'($urandom_range(0, 4));
            h = 4'($urandom_range(0, 4));
            cfg_setup = s; cfg_wait = w; cfg_hold = h;
            if ($urandom_range(0, 1) == 0) begin
                do_write(a, d);
                observe(1, a, d, int'(s), int'(w), int'(h));
            end else begin
                do_read(a);
                observe(0, a, d, int'(s), int'(w), int'(h));
                pop_check(d);
            end
        end

        repeat (3) @(negedge clk);
        check("R10 dma_wr pulses", n_dma_wr, exp_wr);
        check("R10 dma_rd pulses", n_dma_rd, exp_rd);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule